// File: doc/BRIEF.md
# Cycle Counter With Compare Interrupt

A free-running cycle counter shares one register address with a 32-bit compare register. A read strobe at that address returns the current counter value. A write strobe at the same address loads the compare register, which can never be read back. When the low 32 bits of the counter equal the compare value, the block latches an interrupt request. The request stays latched until an acknowledge pulse clears it. An enable input masks the request before it reaches the interrupt output.

Software uses the block by reading the counter and adding an interval to it. It writes the sum back as the next compare point, then services the interrupt and acknowledges it. The counter may be 32 or 64 bits wide. In either case only its low 32 bits take part in the comparison, so a 64-bit counter can match once on every wrap of its low half. Each instance runs on its own and has no link to any other instance.

Top module: `cyc_cmp_timer`

## Requirements
- R1: After reset the counter holds 0. It then increments by exactly 1 on every clock cycle, at the width given by parameter CNT_W (32 or 64), and wraps naturally.
- R2: While rd_en is high, rd_data shows the counter value of that same cycle. While rd_en is low, rd_data is all zeros. A read never returns the compare value.
- R3: On the clock edge where wr_en is high, the compare register loads wr_data. Reset sets the compare register to all ones.
- R4: A match is a cycle in which the low 32 bits of the counter equal the compare register. A match sets the pending flag at the end of that cycle.
- R5: If the compare value is written below the current low 32 bits of the counter, no match occurs until those bits wrap around and reach the value again.
- R6: The irq output is a register that takes the value (pending AND irq_en) on each edge. irq therefore rises two cycles after a match cycle when the mask is open, and it stays low while irq_en is low.
- R7: An irq_ack pulse clears the pending flag at the end of its cycle. irq falls one cycle after that.
- R8: If a match and irq_ack fall in the same cycle, the match wins and the pending flag stays set.
- R9: A write to the compare register never clears a pending flag.
- R10: If irq_en rises while a flag is pending, irq asserts on the next cycle.
- R11: During and right after reset, no flag is pending and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe for the shared address |
| rd_data | output | CNT_W | Counter value while rd_en is high, else zero |
| wr_en | input | 1 | Write strobe; loads the compare register |
| wr_data | input | 32 | New compare value |
| irq_en | input | 1 | Interrupt mask; 1 lets the request through |
| irq_ack | input | 1 | Clears the pending request |
| irq | output | 1 | Registered, masked interrupt request |

## Verification
The hardest case to reach from the ports is an acknowledge that lands exactly on a match cycle while an older request is still pending. The bench reaches it by reading the counter and writing a compare point a known number of cycles ahead. It counts those cycles from the read and then pulses the acknowledge in the match cycle itself. The same read-then-write method places matches while the mask is closed, so the pending state can be seen later by opening the mask. A compare point written behind the counter is checked by watching a long quiet window, because a real 32-bit wrap is out of reach in a bench run.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int CMP_W = 32;

    typedef logic [CMP_W-1:0] cmp_word_t;

    typedef struct packed {
        logic pend;
        logic irq;
    } irq_state_t;

    function automatic logic word_hit(input cmp_word_t a, input cmp_word_t b);
        return a == b;
    endfunction

    function automatic logic next_pend(input logic hit, input logic pend, input logic ack);
        // a match outranks an acknowledge in the same cycle
        return hit | (pend & ~ack);
    endfunction

endpackage

// File: rtl/cct_counter.sv
module cct_counter
    import cct_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count,
    output cmp_word_t        low_word
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_q + ONE;
    end

    assign count = count_q;

    generate
        if (CNT_W > CMP_W) begin : g_wide
            assign low_word = count_q[CMP_W-1:0];
        end else begin : g_narrow
            assign low_word = count_q;
        end
    endgenerate
endmodule

// File: rtl/cct_compare.sv
module cct_compare
    import cct_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  cmp_word_t wr_data,
    input  cmp_word_t low_word,
    output cmp_word_t cmp_value,
    output logic      match
);
    cmp_word_t cmp_q;

    always_ff @(posedge clk) begin
        if (rst)        cmp_q <= '1;
        else if (wr_en) cmp_q <= wr_data;
    end

    assign cmp_value = cmp_q;
    assign match     = word_hit(low_word, cmp_q);
endmodule

// File: rtl/cct_irq_ctl.sv
module cct_irq_ctl
    import cct_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       match,
    input  logic       ack,
    input  logic       irq_en,
    output irq_state_t st
);
    irq_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.pend <= next_pend(match, st_q.pend, ack);
            st_q.irq  <= st_q.pend & irq_en;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/cyc_cmp_timer.sv
module cyc_cmp_timer
    import cct_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    output logic [CNT_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             irq_en,
    input  logic             irq_ack,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_w;
    cmp_word_t        low_w;
    cmp_word_t        cmp_w;
    logic             match_w;
    irq_state_t       st_w;
    logic             pend_w;

    cct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .count    (cnt_w),
        .low_word (low_w)
    );

    cct_compare u_cmp (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .low_word  (low_w),
        .cmp_value (cmp_w),
        .match     (match_w)
    );

    cct_irq_ctl u_irq (
        .clk    (clk),
        .rst    (rst),
        .match  (match_w),
        .ack    (irq_ack),
        .irq_en (irq_en),
        .st     (st_w)
    );

    assign pend_w  = st_w.pend;
    assign irq     = st_w.irq;
    assign rd_data = rd_en ? cnt_w : '0;
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic [CNT_W-1:0] rd_data,
    input logic             wr_en,
    input logic             irq_en,
    input logic             irq_ack,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [31:0]      cmp,
    input logic             pend
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    p_reset_state_r11: assert property (@(posedge clk)
        rst |=> (cnt == '0 && cmp == '1 && !pend && !irq));

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt == $past(cnt) + ONE);

    p_read_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rd_data == '0);

    p_read_count_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> rd_data == cnt);

    p_match_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt[31:0] == cmp) |=> pend);

    p_mask_closed_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && irq |-> $past(irq_en) && $past(pend));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (pend && irq_ack && cnt[31:0] != cmp) |=> !pend);

    p_ack_loses_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && cnt[31:0] == cmp) |=> pend);

    p_write_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (pend && wr_en && !irq_ack) |=> pend);

    p_unmask_r10: assert property (@(posedge clk) disable iff (rst)
        (pend && irq_en) |=> irq);
endmodule

bind cyc_cmp_timer cct_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .irq_en  (irq_en),
    .irq_ack (irq_ack),
    .irq     (irq),
    .cnt     (cnt_w),
    .cmp     (cmp_w),
    .pend    (pend_w)
);

// File: tb/sim_cyc_cmp_timer.sv
`timescale 1ns/1ps
module sim_cyc_cmp_timer;
    localparam int CNT_W = 64;
    localparam int NV = 6;
    localparam int unsigned VEC_D[NV] = '{3, 7, 1, 20, 2, 45};
    localparam bit          VEC_E[NV] = '{1, 1, 0, 1, 0, 1};

    logic             clk = 0;
    logic             rst = 1;
    logic             rd_en = 0;
    logic [CNT_W-1:0] rd_data;
    logic             wr_en = 0;
    logic [31:0]      wr_data = '0;
    logic             irq_en = 0;
    logic             irq_ack = 0;
    logic             irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [CNT_W-1:0] c0;

    always #2.5 clk = ~clk;

    cyc_cmp_timer #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_data(rd_data),
        .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
        .irq_ack(irq_ack), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // read the counter and place the compare point d cycles ahead; returns at cycle 1
    task automatic arm(input int unsigned d);
        rd_en = 1;
        #1;
        c0 = rd_data;
        wr_en = 1;
        wr_data = c0[31:0] + d;
        @(negedge clk);
        rd_en = 0;
        wr_en = 0;
    endtask

    task automatic ack_pulse();
        irq_ack = 1;
        step(1);
        irq_ack = 0;
        step(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] a;
        bit quiet;
        step(3);
        rd_en = 1;
        #1;
        chk("R11 count in reset", rd_data, 0);
        chk("R11 irq in reset", irq, 0);
        rst = 0;
        step(1);
        #1;
        a = rd_data;
        step(1);
        #1;
        chk("R1 increment by one", rd_data, a + 1);
        rd_en = 0;
        #1;
        chk("R2 idle read is zero", rd_data, 0);
        step(1);

        // vector table walk
        irq_en = 1;
        for (int v = 0; v < NV; v++) begin
            irq_en = VEC_E[v];
            arm(VEC_D[v]);
            quiet = 1;
            for (int k = 1; k <= int'(VEC_D[v]) + 1; k++) begin
                if (irq !== 1'b0) quiet = 0;
                step(1);
            end
            chk("R4 no early irq", quiet, 1);
            chk("R6 irq after match", irq, VEC_E[v]);
            if (!VEC_E[v]) begin
                irq_en = 1;
                step(1);
                chk("R10 unmask shows pending", irq, 1);
            end
            ack_pulse();
            chk("R7 ack clears irq", irq, 0);
            step(2);
            chk("R7 stays clear", irq, 0);
        end

        // read returns counter, not compare (R2, R3)
        rd_en = 1;
        wr_en = 1;
        wr_data = 32'h0000_0005;
        #1;
        a = rd_data;
        step(1);
        wr_en = 0;
        #1;
        chk("R2 read gives counter after write", rd_data, a + 1);
        rd_en = 0;

        // compare behind the counter (R5)
        irq_en = 1;
        rd_en = 1;
        #1;
        c0 = rd_data;
        wr_en = 1;
        wr_data = c0[31:0] - 3;
        step(1);
        rd_en = 0;
        wr_en = 0;
        quiet = 1;
        for (int k = 0; k < 300; k++) begin
            if (irq !== 1'b0) quiet = 0;
            step(1);
        end
        chk("R5 behind compare stays quiet", quiet, 1);

        // compare write keeps pending (R9)
        arm(4);
        step(5);
        chk("R9 setup irq", irq, 1);
        rd_en = 1;
        #1;
        wr_en = 1;
        wr_data = rd_data[31:0] + 32'd5000;
        step(1);
        wr_en = 0;
        rd_en = 0;
        quiet = 1;
        for (int k = 0; k < 4; k++) begin
            if (irq !== 1'b1) quiet = 0;
            step(1);
        end
        chk("R9 write keeps pending", quiet, 1);

        // ack in the match cycle while already pending (R8)
        arm(6);
        step(5);
        irq_ack = 1;
        step(1);
        irq_ack = 0;
        step(1);
        chk("R8 match beats ack", irq, 1);
        step(1);
        chk("R8 still pending", irq, 1);
        ack_pulse();
        chk("R7 final clear", irq, 0);

        // mask closed then reopened late (R6, R10)
        irq_en = 0;
        arm(2);
        step(10);
        chk("R6 masked stays low", irq, 0);
        irq_en = 1;
        step(1);
        chk("R10 late unmask", irq, 1);
        ack_pulse();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule